// File: doc/BRIEF.md
# Tiled 3x3 Matrix Multiply Engine

This engine computes the product C = A x B of two signed fixed-point matrices held in a shared word-addressed memory. The matrices can have any size the dimension inputs allow. All arithmetic runs on one fixed 3x3 array of nine multiply-accumulate lanes. The result matrix is built one 3x3 tile at a time.

For each tile, the engine steps through the inner dimension. At each step it fetches a three-element slice of one column of A and a three-element slice of one row of B. All nine lanes then add the outer product of the two slices to their accumulators. When the last inner step is done, the nine sums are written back to memory. The engine then moves three columns to the right. At the end of a band of tiles it moves three rows down and starts again from the left.

At the right and bottom edges a tile may extend past the matrix. Those rows and columns are treated as zero. They are never read from memory and never written back.

A host writes the operands into memory. It then gives three base addresses and the dimensions M, K and N, pulses `start`, and waits for `done`.

Top module: `tile_matmul_engine`

## Requirements
- R1: While reset is active and on the first cycle after it, `busy`, `done`, `rd_en` and `wr_en` are all low.
- R2: A `start` pulse seen while idle captures the three bases and the dimensions M, K and N, each in the range 1..31, and raises `busy` on the next cycle. A `start` seen while `busy` is high is ignored and does not change the run in progress.
- R3: Memory layout is row-major. A[r][k] is at `a_base + r*K + k`, B[k][c] is at `b_base + k*N + c`, and C[r][c] is at `c_base + r*N + c`. Elements are signed two's complement numbers DW bits wide. Each written C element is the low DW bits of the exact sum over k of A[r][k]*B[k][c].
- R4: Memory reads have a latency of one cycle. `rd_data` is taken on the cycle after the cycle in which `rd_en` is high.
- R5: Each inner step of a tile reads the in-range elements of a three-row slice of column k of A, then the in-range elements of a three-column slice of row k of B. k rises from 0 to K-1. A tile therefore makes K*(rows in range + columns in range) reads.
- R6: Rows or columns of a tile that lie outside the matrix are never read and never written. A run writes exactly M*N words, all of them inside the C region. The words just before and just after the C region are left unchanged.
- R7: Tiles are processed with the column tile advancing first, then the row band. Inside a tile, results are written in row-major order.
- R8: All nine accumulators are cleared at the start of every tile, so the sums of one tile never carry into the next.
- R9: A run keeps `busy` high for T*(10+8*K)+1 cycles, where T = ceil(M/3)*ceil(N/3). `done` is high for exactly one cycle, the last cycle of the run.
- R10: `rd_en` and `wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled only while idle |
| a_base | input | AW | Word address of A[0][0] |
| b_base | input | AW | Word address of B[0][0] |
| c_base | input | AW | Word address of C[0][0] |
| dim_m | input | DIMW | Rows of A and C |
| dim_k | input | DIMW | Inner dimension |
| dim_n | input | DIMW | Columns of B and C |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse on the final cycle of a run |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_data | input | DW | Read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DW | Result word being written |

## Verification
The bench builds the engine with DW=16, AW=10 and DIMW=5. With these values, 12x12 operands and a guarded result region fit together in one 1024-word memory.

M, K and N are drawn from 1 to 12. This covers edge tiles that are 1, 2 or 3 wide in each direction and runs of up to sixteen tiles, so both the tile-advance order and the per-tile clear are exercised.

Element values use the full 16-bit signed range. Products and sums therefore reach the accumulator's upper bits, and the low-bit truncation on write-back is tested.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
    localparam int TILE  = 3;
    localparam int LANES = TILE * TILE;
    localparam int SLOTS = 2 * TILE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_FETCH,
        ST_MAC,
        ST_WB,
        ST_DONE
    } tmm_state_e;
endpackage

// File: rtl/tmm_operand_regs.sv
module tmm_operand_regs #(
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic [2:0]            cap_slot,
    input  logic                  cap_vld,
    input  logic [DW-1:0]         rd_data,
    output logic [2:0][DW-1:0]    lhs,
    output logic [2:0][DW-1:0]    rhs
);
    typedef struct packed {
        logic [2:0][DW-1:0] l;
        logic [2:0][DW-1:0] r;
    } opnd_s;

    opnd_s s_d, s_q;
    logic [DW-1:0] word;

    always_comb begin
        s_d  = s_q;
        // slices that fall outside the matrix are captured as zero
        word = cap_vld ? rd_data : '0;
        if (cap_en) begin
            case (cap_slot)
                3'd0: s_d.l[0] = word;
                3'd1: s_d.l[1] = word;
                3'd2: s_d.l[2] = word;
                3'd3: s_d.r[0] = word;
                3'd4: s_d.r[1] = word;
                default: s_d.r[2] = word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lhs = s_q.l;
    assign rhs = s_q.r;
endmodule

// File: rtl/tmm_mac_tile.sv
module tmm_mac_tile #(
    parameter int DW   = 16,
    parameter int ACCW = 37
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic [2:0][DW-1:0]      lhs,
    input  logic [2:0][DW-1:0]      rhs,
    output logic [8:0][ACCW-1:0]    acc
);
    for (genvar i = 0; i < tmm_pkg::TILE; i++) begin : g_row
        for (genvar j = 0; j < tmm_pkg::TILE; j++) begin : g_col
            logic signed [2*DW-1:0] prod;
            logic signed [ACCW-1:0] acc_d, acc_q;

            always_comb begin
                prod  = $signed(lhs[i]) * $signed(rhs[j]);
                acc_d = acc_q;
                if (clr)     acc_d = '0;
                else if (en) acc_d = acc_q + ACCW'(prod);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) acc_q <= '0;
                else        acc_q <= acc_d;
            end

            assign acc[i*tmm_pkg::TILE + j] = acc_q;

            // R8
            acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> (acc_q == '0));
        end
    end
endmodule

// File: rtl/tmm_ctrl.sv
module tmm_ctrl #(
    parameter int AW   = 10,
    parameter int DIMW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   a_base,
    input  logic [AW-1:0]   b_base,
    input  logic [AW-1:0]   c_base,
    input  logic [DIMW-1:0] dim_m,
    input  logic [DIMW-1:0] dim_k,
    input  logic [DIMW-1:0] dim_n,
    output logic            busy,
    output logic            done,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [3:0]      wb_sel,
    output logic            cap_en,
    output logic [2:0]      cap_slot,
    output logic            cap_vld,
    output logic            mac_en,
    output logic            acc_clr
);
    import tmm_pkg::*;

    localparam int XW = DIMW + 1;

    typedef struct packed {
        tmm_state_e      st;
        logic [AW-1:0]   ab;
        logic [AW-1:0]   bb;
        logic [AW-1:0]   cb;
        logic [DIMW-1:0] m;
        logic [DIMW-1:0] k;
        logic [DIMW-1:0] n;
        logic [DIMW-1:0] r0;
        logic [DIMW-1:0] c0;
        logic [DIMW-1:0] kk;
        logic [2:0]      fc;
        logic            pv;
        logic [2:0]      ps;
        logic [1:0]      wr;
        logic [1:0]      wc;
    } ctrl_s;

    ctrl_s s_d, s_q;
    logic [XW-1:0] row_x, col_x;
    logic          in_rng;
    logic [AW-1:0] f_addr;

    always_comb begin
        s_d      = s_q;
        rd_en    = 1'b0;
        rd_addr  = '0;
        wr_en    = 1'b0;
        wr_addr  = '0;
        wb_sel   = '0;
        cap_en   = 1'b0;
        cap_slot = s_q.ps;
        cap_vld  = s_q.pv;
        mac_en   = 1'b0;
        acc_clr  = 1'b0;
        row_x    = '0;
        col_x    = '0;
        in_rng   = 1'b0;
        f_addr   = '0;

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.ab = a_base;
                    s_d.bb = b_base;
                    s_d.cb = c_base;
                    s_d.m  = dim_m;
                    s_d.k  = dim_k;
                    s_d.n  = dim_n;
                    s_d.r0 = '0;
                    s_d.c0 = '0;
                    s_d.st = ST_CLR;
                end
            end
            ST_CLR: begin
                acc_clr = 1'b1;
                s_d.kk  = '0;
                s_d.fc  = '0;
                s_d.st  = ST_FETCH;
            end
            ST_FETCH: begin
                // slots 0..2: left column slice, slots 3..5: right row slice
                if (s_q.fc < 3'd3) begin
                    row_x  = {1'b0, s_q.r0} + XW'(s_q.fc);
                    in_rng = row_x < {1'b0, s_q.m};
                    f_addr = s_q.ab + AW'(row_x) * AW'(s_q.k) + AW'(s_q.kk);
                end else begin
                    col_x  = {1'b0, s_q.c0} + XW'(s_q.fc - 3'd3);
                    in_rng = col_x < {1'b0, s_q.n};
                    f_addr = s_q.bb + AW'(s_q.kk) * AW'(s_q.n) + AW'(col_x);
                end
                if (s_q.fc < 3'd6) begin
                    rd_en   = in_rng;
                    rd_addr = f_addr;
                    s_d.pv  = in_rng;
                    s_d.ps  = s_q.fc;
                end
                // one-cycle read latency: capture the slot issued last cycle
                if (s_q.fc != 3'd0) cap_en = 1'b1;
                if (s_q.fc == 3'd6) s_d.st = ST_MAC;
                else                s_d.fc = s_q.fc + 3'd1;
            end
            ST_MAC: begin
                mac_en = 1'b1;
                if (s_q.kk == s_q.k - DIMW'(1)) begin
                    s_d.wr = '0;
                    s_d.wc = '0;
                    s_d.st = ST_WB;
                end else begin
                    s_d.kk = s_q.kk + DIMW'(1);
                    s_d.fc = '0;
                    s_d.st = ST_FETCH;
                end
            end
            ST_WB: begin
                row_x   = {1'b0, s_q.r0} + XW'(s_q.wr);
                col_x   = {1'b0, s_q.c0} + XW'(s_q.wc);
                wr_en   = (row_x < {1'b0, s_q.m}) && (col_x < {1'b0, s_q.n});
                wr_addr = s_q.cb + AW'(row_x) * AW'(s_q.n) + AW'(col_x);
                wb_sel  = 4'(s_q.wr) * 4'd3 + 4'(s_q.wc);
                if (s_q.wc == 2'd2) begin
                    s_d.wc = '0;
                    if (s_q.wr == 2'd2) begin
                        if (({1'b0, s_q.c0} + XW'(3)) < {1'b0, s_q.n}) begin
                            s_d.c0 = s_q.c0 + DIMW'(3);
                            s_d.st = ST_CLR;
                        end else if (({1'b0, s_q.r0} + XW'(3)) < {1'b0, s_q.m}) begin
                            s_d.r0 = s_q.r0 + DIMW'(3);
                            s_d.c0 = '0;
                            s_d.st = ST_CLR;
                        end else begin
                            s_d.st = ST_DONE;
                        end
                    end else begin
                        s_d.wr = s_q.wr + 2'd1;
                    end
                end else begin
                    s_d.wc = s_q.wc + 2'd1;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != ST_IDLE);
    assign done = (s_q.st == ST_DONE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    // R6
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= s_q.cb) &&
                  (wr_addr < s_q.cb + AW'(s_q.m) * AW'(s_q.n)));

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(s_q.m) && $stable(s_q.k) &&
                             $stable(s_q.n) && $stable(s_q.cb)));
endmodule

// File: rtl/tile_matmul_engine.sv
module tile_matmul_engine #(
    parameter int DW   = 16,
    parameter int AW   = 10,
    parameter int DIMW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   a_base,
    input  logic [AW-1:0]   b_base,
    input  logic [AW-1:0]   c_base,
    input  logic [DIMW-1:0] dim_m,
    input  logic [DIMW-1:0] dim_k,
    input  logic [DIMW-1:0] dim_n,
    output logic            busy,
    output logic            done,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    input  logic [DW-1:0]   rd_data,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data
);
    localparam int ACCW = 2 * DW + DIMW;

    logic               cap_en, cap_vld, mac_en, acc_clr;
    logic [2:0]         cap_slot;
    logic [3:0]         wb_sel;
    logic [2:0][DW-1:0] lhs, rhs;
    logic [8:0][ACCW-1:0] acc;

    tmm_ctrl #(.AW(AW), .DIMW(DIMW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_base(a_base), .b_base(b_base), .c_base(c_base),
        .dim_m(dim_m), .dim_k(dim_k), .dim_n(dim_n),
        .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wb_sel(wb_sel),
        .cap_en(cap_en), .cap_slot(cap_slot), .cap_vld(cap_vld),
        .mac_en(mac_en), .acc_clr(acc_clr)
    );

    tmm_operand_regs #(.DW(DW)) u_opnd (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_slot(cap_slot), .cap_vld(cap_vld),
        .rd_data(rd_data), .lhs(lhs), .rhs(rhs)
    );

    tmm_mac_tile #(.DW(DW), .ACCW(ACCW)) u_tile (
        .clk(clk), .rst_n(rst_n),
        .clr(acc_clr), .en(mac_en),
        .lhs(lhs), .rhs(rhs), .acc(acc)
    );

    assign wr_data = acc[wb_sel][DW-1:0];
endmodule

// File: tb/sim_tile_matmul_engine.sv
`timescale 1ns/1ps
module sim_tile_matmul_engine;
    localparam int DW = 16, AW = 10, DIMW = 5;
    localparam logic [15:0] SENT = 16'hA5A5;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] a_base = '0, b_base = '0, c_base = '0;
    logic [DIMW-1:0] dim_m = '0, dim_k = '0, dim_n = '0;
    logic busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data = '0, wr_data;

    always #2 clk = ~clk;

    tile_matmul_engine #(.DW(DW), .AW(AW), .DIMW(DIMW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_base(a_base), .b_base(b_base), .c_base(c_base),
        .dim_m(dim_m), .dim_k(dim_k), .dim_n(dim_n),
        .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    logic [15:0] mem [1024];
    int wlog [200];
    int wn, rn, bn, dn, ovl;
    int checks = 0, errors = 0;

    always @(posedge clk) begin
        if (rd_en) begin rd_data <= mem[rd_addr]; rn++; end
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            if (wn < 200) wlog[wn] = int'(wr_addr);
            wn++;
        end
        if (rd_en && wr_en) ovl++;
        if (busy) bn++;
        if (done) dn++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mn3(input int x);
        return (x < 3) ? x : 3;
    endfunction

    task automatic run(input int m, input int k, input int n, input bit poke);
        int ab, bb, cb, cyc, tiles, erd, idx;
        longint s;
        logic [15:0] expv;
        int seq [200];
        ab = 4 + int'($urandom % 8);
        bb = 300 + int'($urandom % 8);
        cb = 600 + int'($urandom % 8);
        for (int i = 0; i < 1024; i++) mem[i] = SENT;
        for (int i = 0; i < m * k; i++) mem[ab + i] = 16'($urandom);
        for (int i = 0; i < k * n; i++) mem[bb + i] = 16'($urandom);
        wn = 0; rn = 0; bn = 0; dn = 0; ovl = 0;
        @(negedge clk);
        a_base = AW'(ab); b_base = AW'(bb); c_base = AW'(cb);
        dim_m = DIMW'(m); dim_k = DIMW'(k); dim_n = DIMW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (poke) begin
            repeat (20) @(negedge clk);
            cyc += 20;
            // R2: a second start mid-run with other settings must be ignored
            dim_m = 5'd1; dim_k = 5'd1; dim_n = 5'd1; c_base = 10'd100;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        while (dn == 0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (dn == 0) chk(1'b0, "R9", "watchdog expired", cyc, 0);
        @(negedge clk);
        // R3 R4 R8: every element of C against the triple loop
        for (int r = 0; r < m; r++)
            for (int c = 0; c < n; c++) begin
                s = 0;
                for (int q = 0; q < k; q++)
                    s += longint'($signed(mem[ab + r*k + q])) *
                         longint'($signed(mem[bb + q*n + c]));
                expv = s[15:0];
                chk(mem[cb + r*n + c] == expv, "R3", "C element",
                    longint'(mem[cb + r*n + c]), longint'(expv));
            end
        // R6: guards around C untouched, exact write count
        chk(mem[cb-1] == SENT, "R6", "guard below C", longint'(mem[cb-1]), longint'(SENT));
        chk(mem[cb+m*n] == SENT, "R6", "guard above C", longint'(mem[cb+m*n]), longint'(SENT));
        chk(wn == m*n, "R6", "write count", wn, m*n);
        // R7 tile order and row-major write-back; R5 read count
        tiles = 0; idx = 0; erd = 0;
        for (int r0 = 0; r0 < m; r0 += 3)
            for (int c0 = 0; c0 < n; c0 += 3) begin
                tiles++;
                erd += k * (mn3(m - r0) + mn3(n - c0));
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 3; j++)
                        if (r0 + i < m && c0 + j < n) begin
                            seq[idx] = cb + (r0+i)*n + (c0+j);
                            idx++;
                        end
            end
        for (int i = 0; i < idx && i < wn; i++)
            if (wlog[i] != seq[i]) begin
                chk(1'b0, "R7", "write order", wlog[i], seq[i]);
                break;
            end
        chk(1'b1, "R7", "write order", 0, 0);
        chk(rn == erd, "R5", "read count", rn, erd);
        // R9 busy length and single done pulse
        chk(bn == tiles*(10 + 8*k) + 1, "R9", "busy cycles", bn, tiles*(10 + 8*k) + 1);
        chk(dn == 1, "R9", "done pulses", dn, 1);
        // R10
        chk(ovl == 0, "R10", "read/write overlap", ovl, 0);
        chk(busy == 1'b0, "R2", "idle after run", longint'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: quiet outputs in reset
        chk({busy, done, rd_en, wr_en} == 4'b0, "R1", "outputs in reset",
            longint'({busy, done, rd_en, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, rd_en, wr_en} == 4'b0, "R1", "outputs after reset",
            longint'({busy, done, rd_en, wr_en}), 0);
        run(1, 1, 1, 1'b0);
        run(3, 3, 3, 1'b0);
        run(12, 12, 12, 1'b0);
        run(4, 1, 5, 1'b0);
        run(2, 7, 1, 1'b0);
        run(1, 12, 11, 1'b0);
        run(5, 4, 7, 1'b1);
        for (int t = 0; t < 25; t++)
            run(1 + int'($urandom % 12), 1 + int'($urandom % 12),
                1 + int'($urandom % 12), 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        chk(1'b0, "R9", "global watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule